// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Duty Cycling

This block schedules conversions across a bank of input channels for an oversampling converter. For each enabled channel, in ascending index order, it points the input multiplexer at the channel, waits out a mux settling delay, restarts the decimation filter with that channel's own filter order and decimation factor, and waits for the full filter latency. The first fully settled result is then marked with a one-cycle capture strobe, and the sequencer moves on. Disabled channels are skipped and take no time.

Three run modes are offered. Continuous mode repeats passes back to back. Single mode waits in standby for a rising edge on the sync input, runs one pass and returns to standby. Duty-cycle mode follows every pass with a standby interval three or fifteen times as long as the pass, so the converter is active for one quarter or one sixteenth of each period. The filter itself, the multiplexer and the power circuitry are outside the block. The block only drives their control lines.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is held and directly after it, `standby` is 1, `capture` and `filt_restart` are 0, and `mux_sel` is 0.
- R2: Within a pass, enabled channels (bit i of `ch_en` set) are visited in ascending index order. A disabled channel adds no cycles: the next enabled channel's slot starts directly after the NEXT cycle.
- R3: Each slot begins with a settle phase of max(`ch_settle[i]`, MIN_SETTLE) cycles. MIN_SETTLE is at least 1. Between a capture and the next channel's `filt_restart` there are exactly that many cycles plus 2.
- R4: The convert phase lasts order × max(`ch_fs[i]`,1) × CONV_UNIT cycles, where order is 4 when `ch_ord4[i]` is 1 and 3 otherwise. `capture` rises exactly that many cycles after `filt_restart`.
- R5: While a channel's slot runs, `filt_ord4` and `filt_fs` carry that channel's order bit and its decimation factor (0 promoted to 1).
- R6: `capture` is a single-cycle strobe, low during standby, and `capture_ch` and `mux_sel` name the channel whose result is ready.
- R7: With `run_mode` = 0 (continuous), passes repeat with no standby. The same channel is captured again after exactly one pass length, and `standby` stays 0.
- R8: With `run_mode` = 1 (single), a rising edge of `sync_in` seen in standby starts exactly one pass. Afterwards `standby` returns to 1. Holding `sync_in` high starts no further pass.
- R9: A `sync_in` edge that arrives while a pass is running is ignored and adds no captures.
- R10: With `run_mode` = 2 (duty), each pass of A active cycles is followed by standby of 3·A cycles (`duty_sixteenth` = 0) or 15·A cycles (`duty_sixteenth` = 1). A channel's capture period is therefore 4·A or 16·A.
- R11: `filt_restart` is a one-cycle pulse in the first convert cycle of each slot, never asserted in standby, and `mux_sel` holds through it.
- R12: With no channel enabled, the block stays in standby and produces no capture in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_mode | input | 2 | 0 continuous, 1 single on sync, 2 duty-cycled |
| duty_sixteenth | input | 1 | Duty mode active fraction: 0 one quarter, 1 one sixteenth |
| sync_in | input | 1 | Rising edge starts a pass in single mode |
| ch_en | input | NCH | Channel enable mask |
| ch_ord4 | input | NCH | Per-channel filter order select (1 = fourth order) |
| ch_fs | input | NCH·FS_W | Per-channel decimation factor, channel i at bits i·FS_W upward |
| ch_settle | input | NCH·ST_W | Per-channel mux settle cycles, channel i at bits i·ST_W upward |
| mux_sel | output | CW | Selected input channel |
| filt_restart | output | 1 | Filter restart pulse |
| filt_ord4 | output | 1 | Filter order for the current channel |
| filt_fs | output | FS_W | Decimation factor for the current channel |
| standby | output | 1 | Converter may power down |
| capture | output | 1 | Settled result strobe |
| capture_ch | output | CW | Channel of the captured result |

## Verification
The bench builds the block with four channels, a 3-bit decimation field, a 4-bit settle field, MIN_SETTLE of 3 and CONV_UNIT of 2. With these values, slots of a few tens of cycles can each be timed exactly. The settings reach a settle value below the minimum, a decimation value of zero promoted to one, both filter orders, and a disabled channel in the middle of the mask. Because passes are short, a sixteenth-duty period of several hundred cycles can be measured in full and compared with the pass length.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CONVERT,
      ST_CAPTURE,
      ST_NEXT,
      ST_STANDBY
   } seq_state_e;

   localparam logic [1:0] RUN_CONT   = 2'd0;
   localparam logic [1:0] RUN_SINGLE = 2'd1;
   localparam logic [1:0] RUN_DUTY   = 2'd2;
endpackage

// File: rtl/seq_pick.sv
// Lowest enabled channel whose index is at or above a start point.
module seq_pick #(
   parameter int NCH = 4,
   parameter int CW  = 2
) (
   input  logic [NCH-1:0] en,
   input  logic [CW:0]    from,
   output logic           found,
   output logic [CW-1:0]  idx
);
   logic [NCH-1:0] cand;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_cand
         assign cand[i] = en[i] && (from <= (CW+1)'(i));
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = CW'(i);
         end
      end
   end
endmodule

// File: rtl/seq_timer.sv
// Phase timer: a load of N keeps the phase for N cycles.
module seq_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] len,
   output logic          last
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= len - TW'(1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/seq_duty.sv
// Counts active cycles of a pass and derives the standby length.
module seq_duty #(
   parameter int ACT_W = 12,
   parameter int TW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc,
   input  logic          sixteenth,
   output logic [TW-1:0] stby_len
);
   logic [ACT_W-1:0] act_q;
   logic [TW-1:0]    total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  act_q <= '0;
      else if (clear)              act_q <= '0;
      else if (inc && (act_q != '1)) act_q <= act_q + ACT_W'(1);
   end

   // the NEXT cycle that ends the pass is counted here as the final active cycle
   assign total    = TW'(act_q) + TW'(1);
   assign stby_len = sixteenth ? (total * TW'(15)) : (total * TW'(3));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int NCH        = 4,
   parameter int FS_W       = 3,
   parameter int ST_W       = 4,
   parameter int MIN_SETTLE = 3,
   parameter int CONV_UNIT  = 2,
   parameter int ACT_W      = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           run_mode,
   input  logic                 duty_sixteenth,
   input  logic                 sync_in,
   input  logic [NCH-1:0]       ch_en,
   input  logic [NCH-1:0]       ch_ord4,
   input  logic [NCH*FS_W-1:0]  ch_fs,
   input  logic [NCH*ST_W-1:0]  ch_settle,
   output logic [$clog2(NCH)-1:0] mux_sel,
   output logic                 filt_restart,
   output logic                 filt_ord4,
   output logic [FS_W-1:0]      filt_fs,
   output logic                 standby,
   output logic                 capture,
   output logic [$clog2(NCH)-1:0] capture_ch
);
   import seq_pkg::*;

   localparam int CW = $clog2(NCH);
   localparam int TW = ACT_W + 4;

   generate
      if (NCH < 2)                                      $error("NCH must be 2 or more");
      if (MIN_SETTLE < 1 || MIN_SETTLE >= (1 << ST_W))  $error("MIN_SETTLE out of range");
      if (CONV_UNIT < 1)                                $error("CONV_UNIT must be positive");
      if (4 * ((1 << FS_W) - 1) * CONV_UNIT >= (1 << TW)) $error("timer too narrow");
   endgenerate

   seq_state_e     st_q, st_d;
   logic [CW-1:0]  ch_q, ch_d;
   logic           sync_q, sync_rise, rst_pulse_q;
   logic           first_ok, next_ok;
   logic [CW-1:0]  first_idx, next_idx;
   logic           tmr_load, tmr_last;
   logic [TW-1:0]  tmr_len, stby_len;
   logic           pass_start, active;

   seq_pick #(.NCH(NCH), .CW(CW)) u_first (
      .en(ch_en), .from('0), .found(first_ok), .idx(first_idx));
   seq_pick #(.NCH(NCH), .CW(CW)) u_next (
      .en(ch_en), .from({1'b0, ch_q} + (CW+1)'(1)), .found(next_ok), .idx(next_idx));

   seq_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .last(tmr_last));

   assign active = (st_q == ST_SETTLE) || (st_q == ST_CONVERT) ||
                   (st_q == ST_CAPTURE) || (st_q == ST_NEXT);

   seq_duty #(.ACT_W(ACT_W), .TW(TW)) u_duty (
      .clk(clk), .rst_n(rst_n), .clear(pass_start), .inc(active),
      .sixteenth(duty_sixteenth), .stby_len(stby_len));

   function automatic logic [TW-1:0] settle_of(input logic [CW-1:0] c);
      logic [ST_W-1:0] v;
      v = ch_settle[c*ST_W +: ST_W];
      return (int'(v) < MIN_SETTLE) ? TW'(MIN_SETTLE) : TW'(v);
   endfunction

   function automatic logic [FS_W-1:0] fs_of(input logic [CW-1:0] c);
      logic [FS_W-1:0] v;
      v = ch_fs[c*FS_W +: FS_W];
      return (v == '0) ? FS_W'(1) : v;
   endfunction

   function automatic logic [TW-1:0] conv_of(input logic [CW-1:0] c);
      return TW'(fs_of(c)) * TW'(CONV_UNIT) * (ch_ord4[c] ? TW'(4) : TW'(3));
   endfunction

   assign sync_rise = sync_in && !sync_q;

   always_comb begin
      st_d       = st_q;
      ch_d       = ch_q;
      tmr_load   = 1'b0;
      tmr_len    = '0;
      pass_start = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (first_ok && ((run_mode == RUN_CONT) || (run_mode == RUN_DUTY) ||
                             (run_mode == RUN_SINGLE && sync_rise))) begin
               st_d = ST_SETTLE; ch_d = first_idx; pass_start = 1'b1;
               tmr_load = 1'b1;  tmr_len = settle_of(first_idx);
            end
         end
         ST_SETTLE: begin
            if (tmr_last) begin
               st_d = ST_CONVERT; tmr_load = 1'b1; tmr_len = conv_of(ch_q);
            end
         end
         ST_CONVERT: if (tmr_last) st_d = ST_CAPTURE;
         ST_CAPTURE: st_d = ST_NEXT;
         ST_NEXT: begin
            if (next_ok) begin
               st_d = ST_SETTLE; ch_d = next_idx;
               tmr_load = 1'b1;  tmr_len = settle_of(next_idx);
            end else if (run_mode == RUN_CONT && first_ok) begin
               st_d = ST_SETTLE; ch_d = first_idx; pass_start = 1'b1;
               tmr_load = 1'b1;  tmr_len = settle_of(first_idx);
            end else if (run_mode == RUN_DUTY) begin
               st_d = ST_STANDBY; tmr_load = 1'b1; tmr_len = stby_len;
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_STANDBY: begin
            if (tmr_last) begin
               if (run_mode != RUN_SINGLE && run_mode != 2'd3 && first_ok) begin
                  st_d = ST_SETTLE; ch_d = first_idx; pass_start = 1'b1;
                  tmr_load = 1'b1;  tmr_len = settle_of(first_idx);
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         ch_q        <= '0;
         sync_q      <= 1'b0;
         rst_pulse_q <= 1'b0;
      end else begin
         st_q        <= st_d;
         ch_q        <= ch_d;
         sync_q      <= sync_in;
         rst_pulse_q <= (st_q == ST_SETTLE) && tmr_last;
      end
   end

   assign mux_sel      = ch_q;
   assign capture_ch   = ch_q;
   assign capture      = (st_q == ST_CAPTURE);
   assign filt_restart = rst_pulse_q;
   assign filt_ord4    = ch_ord4[ch_q];
   assign filt_fs      = fs_of(ch_q);
   assign standby      = (st_q == ST_IDLE) || (st_q == ST_STANDBY);
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
   parameter int CW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          capture,
   input logic          filt_restart,
   input logic          standby,
   input logic [CW-1:0] mux_sel
);
   // R6
   cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture);
   // R6
   cap_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !standby);
   // R11
   restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filt_restart |=> !filt_restart);
   // R11
   restart_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filt_restart |-> !standby);
   // R11
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filt_restart |=> $stable(mux_sel));
   // R3
   settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !filt_restart);
endmodule

bind conv_sequencer seq_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .capture(capture), .filt_restart(filt_restart),
   .standby(standby), .mux_sel(mux_sel));

// File: tb/sim_conv_sequencer.sv
`timescale 1ns/1ps
module sim_conv_sequencer;
   localparam int NCH = 4, FS_W = 3, ST_W = 4, MINS = 3, UNIT = 2, ACT_W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] run_mode = 2'd1;
   logic duty_sixteenth = 1'b0, sync_in = 1'b0;
   logic [NCH-1:0] ch_en = '0, ch_ord4 = 4'b0010;
   logic [NCH*FS_W-1:0] ch_fs = {3'd0, 3'd3, 3'd2, 3'd1};
   logic [NCH*ST_W-1:0] ch_settle = {4'd4, 4'd2, 4'd0, 4'd5};
   logic [1:0] mux_sel, capture_ch;
   logic filt_restart, filt_ord4, standby, capture;
   logic [FS_W-1:0] filt_fs;

   conv_sequencer #(.NCH(NCH), .FS_W(FS_W), .ST_W(ST_W), .MIN_SETTLE(MINS),
                    .CONV_UNIT(UNIT), .ACT_W(ACT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .duty_sixteenth(duty_sixteenth),
      .sync_in(sync_in), .ch_en(ch_en), .ch_ord4(ch_ord4), .ch_fs(ch_fs),
      .ch_settle(ch_settle), .mux_sel(mux_sel), .filt_restart(filt_restart),
      .filt_ord4(filt_ord4), .filt_fs(filt_fs), .standby(standby),
      .capture(capture), .capture_ch(capture_ch));

   always #2.5 clk = ~clk;

   int cyc = 0, ncap = 0, nrs = 0, checks = 0, fails = 0;
   int cap_t[256], cap_ch[256], cap_o4[256], cap_fs[256], rs_t[256];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (capture && ncap < 256) begin
         cap_t[ncap] = cyc; cap_ch[ncap] = int'(capture_ch);
         cap_o4[ncap] = int'(filt_ord4); cap_fs[ncap] = int'(filt_fs);
         ncap++;
      end
      if (filt_restart && nrs < 256) begin
         rs_t[nrs] = cyc; nrs++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int s_exp(input int c);
      int v = int'(ch_settle[c*ST_W +: ST_W]);
      return (v < MINS) ? MINS : v;
   endfunction

   function automatic int fs_exp(input int c);
      int v = int'(ch_fs[c*FS_W +: FS_W]);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int l_exp(input int c);
      return (ch_ord4[c] ? 4 : 3) * fs_exp(c) * UNIT;
   endfunction

   function automatic int pass_len();
      int a = 0;
      for (int c = 0; c < NCH; c++) if (ch_en[c]) a += s_exp(c) + l_exp(c) + 2;
      return a;
   endfunction

   function automatic int nth_ch(input int k);
      int n = 0, j = 0;
      for (int c = 0; c < NCH; c++) if (ch_en[c]) n++;
      k = k % n;
      for (int c = 0; c < NCH; c++) if (ch_en[c]) begin
         if (j == k) return c;
         j++;
      end
      return -1;
   endfunction

   task automatic clear_log();
      @(negedge clk); ncap = 0; nrs = 0;
   endtask

   task automatic wait_caps(input int n, input int limit);
      for (int i = 0; i < limit && ncap < n; i++) @(negedge clk);
      @(negedge clk);
   endtask

   // slot-by-slot check of order, settle, convert length and config
   task automatic check_slots(input int n, input bool_gap);
      for (int k = 0; k < n; k++) begin
         int c = nth_ch(k);
         chk("R2 channel order", cap_ch[k], c);
         chk("R4 convert length", cap_t[k] - rs_t[k], l_exp(c));
         chk("R5 order config", cap_o4[k], int'(ch_ord4[c]));
         chk("R5 fs config", cap_fs[k], fs_exp(c));
         if (k > 0 && bool_gap != 0)
            chk("R3 settle gap", rs_t[k] - cap_t[k-1], s_exp(c) + 2);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 standby", int'(standby), 1);
      chk("R1 capture", int'(capture), 0);
      chk("R1 restart", int'(filt_restart), 0);
      chk("R1 mux_sel", int'(mux_sel), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 standby after reset", int'(standby), 1);
   endtask

   task automatic t_continuous();
      ch_en = 4'b1011;
      clear_log();
      run_mode = 2'd0;
      wait_caps(7, 2000);
      check_slots(7, 1);
      chk("R7 repeat period", cap_t[3] - cap_t[0], pass_len());
      chk("R7 awake", int'(standby), 0);
      run_mode = 2'd1;
      repeat (120) @(negedge clk);
      chk("R8 stopped in standby", int'(standby), 1);
   endtask

   task automatic t_single();
      ch_en = 4'b1111;
      clear_log();
      sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
      repeat (20) @(negedge clk);
      sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;   // R9: mid-pass edge
      repeat (300) @(negedge clk);
      chk("R8 one pass", ncap, 4);
      chk("R9 mid-pass sync ignored", ncap, 4);
      check_slots(4, 1);
      chk("R8 back in standby", int'(standby), 1);
      clear_log();
      sync_in = 1'b1;
      repeat (300) @(negedge clk);
      chk("R8 held sync single pass", ncap, 4);
      sync_in = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_duty(input logic six, input int ratio);
      ch_en = 4'b1011;
      duty_sixteenth = six;
      clear_log();
      run_mode = 2'd2;
      wait_caps(3, 3000);
      repeat (3) @(negedge clk);
      chk("R10 standby after pass", int'(standby), 1);
      wait_caps(4, 3000);
      check_slots(3, 1);
      chk("R10 duty period", cap_t[3] - cap_t[0], ratio * pass_len());
      run_mode = 2'd1;
      repeat (ratio * pass_len() + 100) @(negedge clk);
   endtask

   task automatic t_none();
      ch_en = '0;
      clear_log();
      run_mode = 2'd0;
      repeat (60) @(negedge clk);
      chk("R12 no capture", ncap, 0);
      chk("R12 standby", int'(standby), 1);
      run_mode = 2'd1;
   endtask

   initial begin
      t_reset();
      t_continuous();
      t_single();
      t_duty(1'b0, 4);
      t_duty(1'b1, 16);
      t_none();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule